// File: doc/BRIEF.md
# Four-bit multiplexed firmware bus target

This block is the peripheral end of a narrow firmware-storage bus. The bus has a frame strobe (active low) and four shared data lines. A host starts a cycle by pulling the frame strobe low for one clock and placing a code nibble on the lines. The code says whether the cycle is a byte read or a byte write. The host then sends a device-select nibble, a 28-bit address as seven nibbles, and a transfer-size nibble. The target answers only when the select nibble equals its four strap inputs, so up to sixteen targets can share one bus.

After the header the target follows a fixed phase order. On a read it waits through the host's turnaround and drives status nibbles while it fetches the byte from a synchronous byte-memory port. It then returns the byte as two nibbles and hands the bus back. On a write the host sends the two data nibbles first. The target then takes the bus for a single ready status, commits the byte (if the write-permit input allows it) and hands the bus back.

The shared lines appear as a separate input, output and output enable. If the host pulls the frame strobe low in the middle of a cycle, the target abandons the cycle and goes quiet.

Top module: `fhub_target`

## Requirements
- R1: While `rst` is high, and in the first clock after it falls, `bus_oe`, `mem_rd` and `mem_wr` are all low.
- R2: A cycle starts only in a clock where `frame_n` is low and `bus_in` is 1101 (read) or 1110 (write). With any other nibble under a low strobe the target never drives the bus and never strobes memory for that cycle.
- R3: The nibble in the clock after the start is compared with `strap_id`. On a mismatch the target stays silent for the whole cycle, with no bus drive and no memory strobe.
- R4: The seven clocks after the select nibble carry the address, most significant nibble first. `mem_addr` equals the low `MEM_AW` bits of the collected 28-bit address whenever a memory strobe is raised.
- R5: The clock after the address carries the size nibble. Only 0000 is served. Any other value makes the target ignore the cycle, with no drive and no strobe.
- R6: On a read, the two clocks after the size nibble leave the bus released. The target then drives 0101 for `WAIT_CNT` clocks, then 0000 for one clock. `mem_rd` is high for exactly one clock, the first status clock.
- R7: On a read, the ready status is followed by the byte, low nibble then high nibble. Then comes one clock of 1111, after which the bus is released.
- R8: On a write, the two clocks after the size nibble carry the data, low nibble first. Two released clocks follow. Then comes one clock of 0000 in which `mem_wr` is high with `mem_wdata` holding the byte. Then one clock of 1111, after which the bus is released.
- R9: If `wr_permit` is low in the write's status clock, the bus handshake is unchanged but `mem_wr` stays low, and a later read of that address returns the old byte.
- R10: If `frame_n` goes low while a cycle is in progress, the target releases the bus from the next clock on and raises no further strobe for that cycle. A new cycle is accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle frame strobe, active low |
| bus_in | input | 4 | Nibble seen on the shared data lines |
| bus_out | output | 4 | Nibble the target drives |
| bus_oe | output | 1 | Target drives the shared lines when high |
| strap_id | input | 4 | Board-strapped device number |
| wr_permit | input | 1 | Allows the memory update of a write |
| mem_addr | output | MEM_AW | Byte address to the memory port |
| mem_rd | output | 1 | One-clock read request; data is returned on the next clock |
| mem_rdata | input | 8 | Read data from the memory port |
| mem_wr | output | 1 | One-clock write strobe |
| mem_wdata | output | 8 | Byte to be written |

## Verification
The bench builds the target with `MEM_AW` of 10, seven address nibbles and two wait statuses. The small memory port makes a complete byte model cheap. The narrow width means every address sent with nonzero upper nibbles checks that those bits are dropped while the low bits keep their order. The two-clock wait window lets the bench see the read strobe, the fetch latency and the ready nibble as separate clocks. This makes an early or late data capture visible on the data nibbles.

// File: rtl/fhub_pkg.sv
package fhub_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SEL,
        PH_ADDR,
        PH_SIZE,
        PH_WDATA,
        PH_TURN_IN,
        PH_STAT,
        PH_RDATA,
        PH_TURN_OUT
    } phase_e;

    localparam logic [3:0] CODE_RD    = 4'b1101;
    localparam logic [3:0] CODE_WR    = 4'b1110;
    localparam logic [3:0] STAT_WAIT  = 4'b0101;
    localparam logic [3:0] STAT_READY = 4'b0000;
    localparam logic [3:0] SIZE_BYTE  = 4'b0000;
    localparam logic [3:0] NIB_IDLE   = 4'b1111;

    function automatic logic is_start(input logic [3:0] n);
        return (n == CODE_RD) || (n == CODE_WR);
    endfunction

endpackage

// File: rtl/fhub_seq.sv
module fhub_seq
    import fhub_pkg::*;
#(
    parameter int ADDR_NIB = 7,
    parameter int WAIT_CNT = 2,
    parameter int CW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_n,
    input  logic [3:0]    nib,
    input  logic [3:0]    strap,
    output phase_e        ph,
    output logic [CW-1:0] cnt,
    output logic          is_wr
);

    logic [CW-1:0] plen;
    logic          last;
    phase_e        nxt;

    // number of clocks spent in the current phase
    always_comb begin
        case (ph)
            PH_ADDR:                                 plen = CW'(ADDR_NIB);
            PH_WDATA, PH_TURN_IN, PH_RDATA,
            PH_TURN_OUT:                             plen = CW'(2);
            PH_STAT:  plen = is_wr ? CW'(1) : CW'(WAIT_CNT + 1);
            default:                                 plen = CW'(1);
        endcase
    end

    assign last = (cnt == plen - CW'(1));

    always_comb begin
        case (ph)
            PH_IDLE:     nxt = (!frame_n && is_start(nib)) ? PH_SEL : PH_IDLE;
            PH_SEL:      nxt = (nib == strap) ? PH_ADDR : PH_IDLE;
            PH_ADDR:     nxt = PH_SIZE;
            PH_SIZE:     nxt = (nib != SIZE_BYTE) ? PH_IDLE
                             : (is_wr ? PH_WDATA : PH_TURN_IN);
            PH_WDATA:    nxt = PH_TURN_IN;
            PH_TURN_IN:  nxt = PH_STAT;
            PH_STAT:     nxt = is_wr ? PH_TURN_OUT : PH_RDATA;
            PH_RDATA:    nxt = PH_TURN_OUT;
            default:     nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            is_wr <= 1'b0;
        end else if (ph != PH_IDLE && !frame_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else if (last) begin
            ph  <= nxt;
            cnt <= '0;
            if (ph == PH_IDLE) is_wr <= (nib == CODE_WR);
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/fhub_collect.sv
module fhub_collect
    import fhub_pkg::*;
#(
    parameter int MEM_AW = 16,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            ph,
    input  logic [CW-1:0]     cnt,
    input  logic [3:0]        nib,
    input  logic [7:0]        mem_rdata,
    output logic [MEM_AW-1:0] addr_q,
    output logic [7:0]        wdat_q,
    output logic [7:0]        rdat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else begin
            // most significant nibble arrives first; keep only the low bits
            if (ph == PH_ADDR) addr_q <= MEM_AW'({addr_q, nib});
            if (ph == PH_WDATA) begin
                if (cnt == '0) wdat_q[3:0] <= nib;
                else           wdat_q[7:4] <= nib;
            end
            // memory answers one clock after the request in status clock 0
            if (ph == PH_STAT && cnt == CW'(1)) rdat_q <= mem_rdata;
        end
    end

endmodule

// File: rtl/fhub_drive.sv
module fhub_drive
    import fhub_pkg::*;
#(
    parameter int WAIT_CNT = 2,
    parameter int CW       = 4
) (
    input  phase_e        ph,
    input  logic [CW-1:0] cnt,
    input  logic          is_wr,
    input  logic          wr_permit,
    input  logic [7:0]    rdat,
    output logic [3:0]    bus_out,
    output logic          bus_oe,
    output logic          mem_rd,
    output logic          mem_wr
);

    always_comb begin
        bus_oe  = 1'b0;
        bus_out = NIB_IDLE;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        case (ph)
            PH_STAT: begin
                bus_oe = 1'b1;
                if (is_wr) begin
                    bus_out = STAT_READY;
                    mem_wr  = wr_permit;
                end else begin
                    bus_out = (cnt == CW'(WAIT_CNT)) ? STAT_READY : STAT_WAIT;
                    mem_rd  = (cnt == '0);
                end
            end
            PH_RDATA: begin
                bus_oe  = 1'b1;
                bus_out = (cnt == '0) ? rdat[3:0] : rdat[7:4];
            end
            PH_TURN_OUT: begin
                bus_oe  = (cnt == '0);
                bus_out = NIB_IDLE;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fhub_target.sv
module fhub_target
    import fhub_pkg::*;
#(
    parameter int ADDR_NIB = 7,
    parameter int MEM_AW   = 16,
    parameter int WAIT_CNT = 2   // must be at least 1 to cover the fetch latency
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    input  logic [3:0]        strap_id,
    input  logic              wr_permit,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata
);

    localparam int CW = $clog2(ADDR_NIB + WAIT_CNT + 2);

    phase_e        ph;
    logic [CW-1:0] cnt;
    logic          is_wr;
    logic [7:0]    rdat;

    fhub_seq #(.ADDR_NIB(ADDR_NIB), .WAIT_CNT(WAIT_CNT), .CW(CW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .nib     (bus_in),
        .strap   (strap_id),
        .ph      (ph),
        .cnt     (cnt),
        .is_wr   (is_wr)
    );

    fhub_collect #(.MEM_AW(MEM_AW), .CW(CW)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .cnt       (cnt),
        .nib       (bus_in),
        .mem_rdata (mem_rdata),
        .addr_q    (mem_addr),
        .wdat_q    (mem_wdata),
        .rdat_q    (rdat)
    );

    fhub_drive #(.WAIT_CNT(WAIT_CNT), .CW(CW)) u_drive (
        .ph        (ph),
        .cnt       (cnt),
        .is_wr     (is_wr),
        .wr_permit (wr_permit),
        .rdat      (rdat),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

endmodule

// File: rtl/fhub_target_chk.sv
module fhub_target_chk
    import fhub_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frame_n,
    input logic [3:0] bus_out,
    input logic       bus_oe,
    input logic       mem_rd,
    input logic       mem_wr
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!bus_oe && !mem_rd && !mem_wr));

    // R10
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_n && bus_oe) |=> !bus_oe);

    // R7
    handback_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_oe) && $past(frame_n)) |-> ($past(bus_out) == NIB_IDLE));

    // R6
    first_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> (bus_out == STAT_WAIT || bus_out == STAT_READY));

    // R6
    fetch_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (bus_oe && bus_out == STAT_WAIT));

    // R8
    store_on_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (bus_oe && bus_out == STAT_READY));

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

endmodule

bind fhub_target fhub_target_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .frame_n (frame_n),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr)
);

// File: tb/fhub_target_bench.sv
module fhub_target_bench;

    localparam int MEM_AW = 10;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam logic [3:0] STRAP = 4'hA;

    typedef struct packed {
        logic              oe;
        logic [3:0]        out;
        logic              rd;
        logic              wr;
        logic [MEM_AW-1:0] addr;
        logic [7:0]        wd;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_n = 1'b1;
    logic [3:0]        bus_in = 4'hF;
    logic [3:0]        bus_out;
    logic              bus_oe;
    logic              wr_permit = 1'b1;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_rd;
    logic [7:0]        mem_rdata;
    logic              mem_wr;
    logic [7:0]        mem_wdata;

    logic [7:0] mem    [DEPTH];
    logic [7:0] shadow [DEPTH];
    exp_t  exp_q[$];
    string req_q[$];
    exp_t  e;
    string r;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    fhub_target #(.ADDR_NIB(7), .MEM_AW(MEM_AW), .WAIT_CNT(2)) u_fhub_target (
        .clk(clk), .rst(rst), .frame_n(frame_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .strap_id(STRAP),
        .wr_permit(wr_permit), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    // synchronous byte memory: read data one clock after the request
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
        end else begin
            if (mem_wr) mem[mem_addr] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr];
        end
    end

    function automatic exp_t mk(input logic oe, input logic [3:0] out, input logic rd,
                                input logic wr, input logic [MEM_AW-1:0] a, input logic [7:0] d);
        exp_t x;
        x.oe = oe; x.out = out; x.rd = rd; x.wr = wr; x.addr = a; x.wd = d;
        return x;
    endfunction

    function automatic exp_t quiet();
        return mk(1'b0, 4'hF, 1'b0, 1'b0, '0, 8'h00);
    endfunction

    // driver: one bus clock, pushing what the outputs must show in it
    task automatic slot(input logic fr, input logic [3:0] nib, input exp_t x, input string req);
        @(negedge clk);
        exp_q.push_back(x);
        req_q.push_back(req);
        frame_n = fr;
        bus_in  = nib;
    endtask

    task automatic header(input logic [3:0] code, input logic [3:0] id,
                          input logic [27:0] a, input logic [3:0] size, input string req);
        slot(1'b0, code, quiet(), req);
        slot(1'b1, id, quiet(), req);
        for (int k = 0; k < 7; k++) slot(1'b1, a[27-4*k -: 4], quiet(), req);
        slot(1'b1, size, quiet(), req);
    endtask

    task automatic do_read(input logic [3:0] code, input logic [3:0] id, input logic [27:0] a,
                           input logic [3:0] size, input logic resp, input string req);
        logic [MEM_AW-1:0] la;
        logic [7:0] d;
        la = a[MEM_AW-1:0];
        d  = shadow[la];
        header(code, id, a, size, req);
        slot(1'b1, 4'hF, quiet(), req);
        slot(1'b1, 4'hF, quiet(), req);
        if (resp) begin
            slot(1'b1, 4'hF, mk(1'b1, 4'b0101, 1'b1, 1'b0, la, 8'h00), req);
            slot(1'b1, 4'hF, mk(1'b1, 4'b0101, 1'b0, 1'b0, la, 8'h00), req);
            slot(1'b1, 4'hF, mk(1'b1, 4'b0000, 1'b0, 1'b0, la, 8'h00), req);
            slot(1'b1, 4'hF, mk(1'b1, d[3:0], 1'b0, 1'b0, la, 8'h00), {req, " R7"});
            slot(1'b1, 4'hF, mk(1'b1, d[7:4], 1'b0, 1'b0, la, 8'h00), {req, " R7"});
            slot(1'b1, 4'hF, mk(1'b1, 4'hF, 1'b0, 1'b0, la, 8'h00), {req, " R7"});
            slot(1'b1, 4'hF, quiet(), {req, " R7"});
        end else begin
            for (int k = 0; k < 7; k++) slot(1'b1, 4'hF, quiet(), req);
        end
    endtask

    task automatic do_write(input logic [3:0] id, input logic [27:0] a, input logic [7:0] d,
                            input logic [3:0] size, input logic permit, input logic resp,
                            input string req);
        logic [MEM_AW-1:0] la;
        la = a[MEM_AW-1:0];
        wr_permit = permit;
        header(4'b1110, id, a, size, req);
        slot(1'b1, d[3:0], quiet(), req);
        slot(1'b1, d[7:4], quiet(), req);
        slot(1'b1, 4'hF, quiet(), req);
        slot(1'b1, 4'hF, quiet(), req);
        if (resp) begin
            slot(1'b1, 4'hF, mk(1'b1, 4'b0000, 1'b0, permit, la, d), req);
            slot(1'b1, 4'hF, mk(1'b1, 4'hF, 1'b0, 1'b0, la, d), req);
            slot(1'b1, 4'hF, quiet(), req);
            if (permit) shadow[la] = d;
        end else begin
            for (int k = 0; k < 3; k++) slot(1'b1, 4'hF, quiet(), req);
        end
        wr_permit = 1'b1;
    endtask

    // monitor: compare mid-cycle, well clear of both clock edges
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            n_cmp++;
            if (bus_oe !== e.oe || (e.oe && bus_out !== e.out) || mem_rd !== e.rd ||
                mem_wr !== e.wr || ((e.rd || e.wr) && mem_addr !== e.addr) ||
                (e.wr && mem_wdata !== e.wd)) begin
                n_bad++;
                $display("FAIL %s: got oe=%b out=%h rd=%b wr=%b addr=%h wd=%h, expected oe=%b out=%h rd=%b wr=%b addr=%h wd=%h",
                         r, bus_oe, bus_out, mem_rd, mem_wr, mem_addr, mem_wdata,
                         e.oe, e.out, e.rd, e.wr, e.addr, e.wd);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got no end of stimulus, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) shadow[i] = pat(i);
        // R1: quiet during reset and just after release
        for (int k = 0; k < 3; k++) slot(1'b1, 4'hF, quiet(), "R1 reset");
        rst = 1'b0;
        slot(1'b1, 4'hF, quiet(), "R1 after reset");

        // R6 R7: plain read
        do_read(4'b1101, STRAP, 28'h0000123, 4'h0, 1'b1, "R6 read");
        // R8: write, then read back the new byte
        do_write(STRAP, 28'h0002055, 8'h3C, 4'h0, 1'b1, 1'b1, "R8 write");
        do_read(4'b1101, STRAP, 28'h0002055, 4'h0, 1'b1, "R8 readback");
        // R9: blocked write keeps the old byte
        do_write(STRAP, 28'h0000077, 8'hA5, 4'h0, 1'b0, 1'b1, "R9 blocked write");
        do_read(4'b1101, STRAP, 28'h0000077, 4'h0, 1'b1, "R9 readback");
        // R4: upper nibbles dropped, order kept
        do_read(4'b1101, STRAP, 28'hABCD3F1, 4'h0, 1'b1, "R4 high address");
        do_write(STRAP, 28'h9876E12, 8'h5A, 4'h0, 1'b1, 1'b1, "R4 high address write");
        do_read(4'b1101, STRAP, 28'h0000212, 4'h0, 1'b1, "R4 aliased readback");
        // R3: other device numbers
        do_read(4'b1101, 4'h5, 28'h0000010, 4'h0, 1'b0, "R3 foreign read");
        do_write(4'hB, 28'h0000010, 8'hEE, 4'h0, 1'b1, 1'b0, "R3 foreign write");
        do_read(4'b1101, STRAP, 28'h0000010, 4'h0, 1'b1, "R3 untouched");
        // R5: unsupported sizes
        do_read(4'b1101, STRAP, 28'h0000020, 4'h1, 1'b0, "R5 size read");
        do_write(STRAP, 28'h0000020, 8'h11, 4'h2, 1'b1, 1'b0, "R5 size write");
        do_read(4'b1101, STRAP, 28'h0000020, 4'h0, 1'b1, "R5 untouched");
        // R2: unknown start code
        do_read(4'b1010, STRAP, 28'h0000030, 4'h0, 1'b0, "R2 bad code");
        do_read(4'b1111, STRAP, 28'h0000030, 4'h0, 1'b0, "R2 idle code");

        // R10: abort while the target drives status
        header(4'b1101, STRAP, 28'h0000040, 4'h0, "R10 abort");
        slot(1'b1, 4'hF, quiet(), "R10 abort");
        slot(1'b1, 4'hF, quiet(), "R10 abort");
        slot(1'b1, 4'hF, mk(1'b1, 4'b0101, 1'b1, 1'b0, 10'h040, 8'h00), "R10 abort");
        slot(1'b0, 4'hF, mk(1'b1, 4'b0101, 1'b0, 1'b0, 10'h040, 8'h00), "R10 abort");
        for (int k = 0; k < 4; k++) slot(1'b1, 4'hF, quiet(), "R10 released");
        // R10: abort in the address phase of a write, then a normal cycle
        slot(1'b0, 4'b1110, quiet(), "R10 abort write");
        slot(1'b1, STRAP, quiet(), "R10 abort write");
        for (int k = 0; k < 3; k++) slot(1'b1, 4'h0, quiet(), "R10 abort write");
        slot(1'b0, 4'h0, quiet(), "R10 abort write");
        for (int k = 0; k < 10; k++) slot(1'b1, 4'h0, quiet(), "R10 released");
        do_read(4'b1101, STRAP, 28'h0000000, 4'h0, 1'b1, "R10 recovery");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule